// File: doc/BRIEF.md
# Half-Duplex Transmit Collision Status Tracker

This block follows one outgoing frame through its transmit attempts on a shared half-duplex medium. The surrounding MAC reports events to it: frame start, attempt start (the first preamble byte), successful end of attempt, collision, carrier sense, byte-time ticks and bit-time ticks. From these events the block decides after each collision whether to retry or to give up. It keeps the collision tally, measures how far into the attempt a collision falls, and limits how long the frame may wait for the medium.

Between attempts the block requests a retry and waits for a backoff-done input from an external backoff timer. When the frame ends, by success or by abort, the block raises a one-cycle done pulse. The status fields then hold their values until the next frame is accepted. The status covers the collision tally, the excessive-collision, late-collision and excessive-deferral flags, a deferred flag and a summary error flag.

Top module: `hdx_txstat_tracker`

## Requirements
- R1: After reset, and after `frame_start` is accepted in the idle state, `done`, `retry_req` and all status outputs read zero.
- R2: `tx_end` during an attempt without a collision in the same cycle ends the frame. `done` pulses in the cycle after the edge that sampled `tx_end`, and `st_col_cnt` equals the number of earlier collisions in this frame.
- R3: A collision that is neither late nor the aborting one raises `retry_req`. The request stays high until `backoff_done` is sampled, then drops, and the next attempt may start.
- R4: The 16th collision of a frame aborts it with `st_excess_col` = 1. Whenever `st_excess_col` is 1, `st_col_cnt` reads 0 to mark the tally as not valid.
- R5: With `retry_disable` high, the first collision aborts the frame with `st_excess_col` = 1 and no retry request.
- R6: A collision is late when 64 or more `byte_tick` pulses have been sampled since the attempt started (the preamble counts). A late collision aborts the frame with `st_late_col` = 1, no retry, and `st_col_cnt` equal to the earlier collisions. A collision after 63 ticks is not late.
- R7: With `defer_chk_en` high and `jumbo_en` low, the 24289th `bit_tick` sampled with `crs_in` high while waiting to start an attempt aborts the frame with `st_excess_defer` = 1. With `defer_chk_en` low, no deferral abort occurs. The deferral count stops at the selected limit and does not wrap.
- R8: With `jumbo_en` high the deferral limit is 155680 bit times. A count held at the standard limit resumes counting up to that larger limit.
- R9: `st_deferred` becomes 1 when `crs_in` is high during deferral in the current frame. Otherwise it stays 0.
- R10: At `done`, `st_err` is the OR of `st_excess_col`, `st_late_col` and `st_excess_defer`, and at most one of those three is set.
- R11: `done` lasts one cycle. In the idle state, status outputs stay unchanged until the next `frame_start`.
- R12: Every count restarts at the start of the next frame, so a clean frame after one with collisions reports a tally of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | New frame; accepted only when idle |
| attempt_start | input | 1 | Attempt begins (first preamble byte) |
| tx_end | input | 1 | Attempt finished without collision |
| col_in | input | 1 | Collision seen on the medium |
| crs_in | input | 1 | Carrier sensed |
| byte_tick | input | 1 | One byte time elapsed |
| bit_tick | input | 1 | One bit time elapsed |
| backoff_done | input | 1 | External backoff delay finished |
| retry_disable | input | 1 | Abort on the first collision |
| defer_chk_en | input | 1 | Enable the deferral limit |
| jumbo_en | input | 1 | Use the jumbo deferral limit |
| retry_req | output | 1 | Waiting for backoff before retrying |
| done | output | 1 | One-cycle end-of-frame pulse |
| st_col_cnt | output | 4 | Collision tally (0 when excessive) |
| st_excess_col | output | 1 | Aborted for too many collisions |
| st_late_col | output | 1 | Aborted by a late collision |
| st_excess_defer | output | 1 | Aborted by excessive deferral |
| st_deferred | output | 1 | Carrier was sensed during deferral |
| st_err | output | 1 | Summary error flag |

## Verification
The hardest condition to reach from the ports is the jumbo deferral limit. It lies 155680 carrier-busy bit times into a single deferral, which leaves room for only one run of that length within the cycle budget. The stimulus first defers past the standard limit with checking off, which shows that no abort occurs and parks the count at 24288. It then turns on jumbo mode and checking together, so the same deferral keeps counting to the larger limit. The bench checks that the abort comes on exactly the expected tick. The 16-collision abort is reached through a vector entry that runs fifteen retry handshakes before the aborting collision.

// File: rtl/hdx_txstat_pkg.sv
package hdx_txstat_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DEFER   = 2'd1,
    ST_XMIT    = 2'd2,
    ST_BACKOFF = 2'd3
  } hdx_state_e;

  // deferral limit selected by jumbo mode
  function automatic int defer_limit(input logic jumbo, input int lim_std, input int lim_jumbo);
    return jumbo ? lim_jumbo : lim_std;
  endfunction

  // true when the collision about to be counted ends the frame
  function automatic logic col_exhausted(input int seen, input int max_col, input logic no_retry);
    return no_retry || ((seen + 1) >= max_col);
  endfunction

  // collision is late once the window of byte times has fully elapsed
  function automatic logic is_late(input int bytes_seen, input int window);
    return bytes_seen >= window;
  endfunction

endpackage

// File: rtl/hdx_col_counter.sv
module hdx_col_counter
  import hdx_txstat_pkg::*;
#(
  parameter int MAX_COL = 16,
  parameter int CC_W    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            inc,
  input  logic            no_retry,
  output logic [CC_W-1:0] tally,
  output logic            exhaust
);
  localparam int COL_W = $clog2(MAX_COL + 1);

  logic [COL_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (clr)
      count <= '0;
    else if (inc && (count < COL_W'(MAX_COL)))
      count <= count + 1'b1;
  end

  assign tally   = count[CC_W-1:0];
  assign exhaust = col_exhausted(int'(count), MAX_COL, no_retry);

  p_col_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= COL_W'(MAX_COL));

  p_col_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr) |=> (count == '0));

endmodule

// File: rtl/hdx_col_window.sv
module hdx_col_window
  import hdx_txstat_pkg::*;
#(
  parameter int WIN_BYTES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic byte_tick,
  output logic late
);
  localparam int WIN_W = $clog2(WIN_BYTES + 1);

  logic [WIN_W-1:0] bytes_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bytes_q <= '0;
    else if (clr)
      bytes_q <= '0;
    else if (run && byte_tick && (bytes_q < WIN_W'(WIN_BYTES)))
      bytes_q <= bytes_q + 1'b1;
  end

  assign late = is_late(int'(bytes_q), WIN_BYTES);

  p_win_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bytes_q <= WIN_W'(WIN_BYTES));

  p_late_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (late && !clr) |=> late);

endmodule

// File: rtl/hdx_defer_timer.sv
module hdx_defer_timer
  import hdx_txstat_pkg::*;
#(
  parameter int LIM_STD   = 24288,
  parameter int LIM_JUMBO = 155680
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic bit_tick,
  input  logic crs,
  input  logic chk_en,
  input  logic jumbo,
  output logic over
);
  localparam int DEF_W = $clog2(LIM_JUMBO + 1);

  logic [DEF_W-1:0] wait_q;
  logic [DEF_W-1:0] lim_sel;
  logic             busy_tick;

  assign lim_sel   = DEF_W'(defer_limit(jumbo, LIM_STD, LIM_JUMBO));
  assign busy_tick = run && bit_tick && crs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wait_q <= '0;
    else if (clr)
      wait_q <= '0;
    else if (busy_tick && (wait_q < lim_sel))
      wait_q <= wait_q + 1'b1;
  end

  // one more busy bit time beyond the limit ends the frame
  assign over = busy_tick && chk_en && (wait_q >= lim_sel);

  p_wait_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q <= DEF_W'(LIM_JUMBO));

  p_wait_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(wait_q));

endmodule

// File: rtl/hdx_txstat_tracker.sv
module hdx_txstat_tracker
  import hdx_txstat_pkg::*;
#(
  parameter int MAX_COL         = 16,
  parameter int CC_W            = 4,
  parameter int WIN_BYTES       = 64,
  parameter int DEFER_LIM       = 24288,
  parameter int DEFER_LIM_JUMBO = 155680
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            attempt_start,
  input  logic            tx_end,
  input  logic            col_in,
  input  logic            crs_in,
  input  logic            byte_tick,
  input  logic            bit_tick,
  input  logic            backoff_done,
  input  logic            retry_disable,
  input  logic            defer_chk_en,
  input  logic            jumbo_en,
  output logic            retry_req,
  output logic            done,
  output logic [CC_W-1:0] st_col_cnt,
  output logic            st_excess_col,
  output logic            st_late_col,
  output logic            st_excess_defer,
  output logic            st_deferred,
  output logic            st_err
);

  hdx_state_e      state;
  logic [CC_W-1:0] tally;
  logic            exhaust, late, defer_over;

  // named event wires
  logic ev_start, ev_attempt, ev_col, ev_late, ev_early;
  logic ev_excess, ev_retry, ev_ok, ev_defer, ev_finish;

  assign ev_start   = (state == ST_IDLE) && frame_start;
  assign ev_defer   = (state == ST_DEFER) && defer_over;
  assign ev_attempt = (state == ST_DEFER) && attempt_start && !defer_over;
  assign ev_col     = (state == ST_XMIT) && col_in;
  assign ev_late    = ev_col && late;
  assign ev_early   = ev_col && !late;
  assign ev_excess  = ev_early && exhaust;
  assign ev_retry   = ev_early && !exhaust;
  assign ev_ok      = (state == ST_XMIT) && !col_in && tx_end;
  assign ev_finish  = ev_ok || ev_late || ev_excess || ev_defer;

  hdx_col_counter #(.MAX_COL(MAX_COL), .CC_W(CC_W)) u_cols (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ev_start),
    .inc      (ev_early),
    .no_retry (retry_disable),
    .tally    (tally),
    .exhaust  (exhaust)
  );

  hdx_col_window #(.WIN_BYTES(WIN_BYTES)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ev_attempt),
    .run       (state == ST_XMIT),
    .byte_tick (byte_tick),
    .late      (late)
  );

  hdx_defer_timer #(.LIM_STD(DEFER_LIM), .LIM_JUMBO(DEFER_LIM_JUMBO)) u_defer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ev_start || ev_attempt),
    .run      (state == ST_DEFER),
    .bit_tick (bit_tick),
    .crs      (crs_in),
    .chk_en   (defer_chk_en),
    .jumbo    (jumbo_en),
    .over     (defer_over)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state           <= ST_IDLE;
      done            <= 1'b0;
      st_col_cnt      <= '0;
      st_excess_col   <= 1'b0;
      st_late_col     <= 1'b0;
      st_excess_defer <= 1'b0;
      st_deferred     <= 1'b0;
      st_err          <= 1'b0;
    end else begin
      done <= ev_finish;
      unique case (state)
        ST_IDLE: if (frame_start) begin
          state           <= ST_DEFER;
          st_col_cnt      <= '0;
          st_excess_col   <= 1'b0;
          st_late_col     <= 1'b0;
          st_excess_defer <= 1'b0;
          st_deferred     <= 1'b0;
          st_err          <= 1'b0;
        end
        ST_DEFER: begin
          if (crs_in) st_deferred <= 1'b1;
          if (defer_over) begin
            state           <= ST_IDLE;
            st_excess_defer <= 1'b1;
            st_err          <= 1'b1;
            st_col_cnt      <= tally;
          end else if (attempt_start) begin
            state <= ST_XMIT;
          end
        end
        ST_XMIT: begin
          if (ev_late) begin
            state       <= ST_IDLE;
            st_late_col <= 1'b1;
            st_err      <= 1'b1;
            st_col_cnt  <= tally;
          end else if (ev_excess) begin
            state         <= ST_IDLE;
            st_excess_col <= 1'b1;
            st_err        <= 1'b1;
            st_col_cnt    <= '0;
          end else if (ev_retry) begin
            state <= ST_BACKOFF;
          end else if (ev_ok) begin
            state      <= ST_IDLE;
            st_col_cnt <= tally;
          end
        end
        ST_BACKOFF: if (backoff_done) state <= ST_DEFER;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign retry_req = (state == ST_BACKOFF);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_sum_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (st_err == (st_excess_col | st_late_col | st_excess_defer)));

  p_one_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({st_excess_col, st_late_col, st_excess_defer}) <= 1));

  p_retry_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_req && !backoff_done) |=> retry_req);

  p_late_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_XMIT) && col_in && late) |=> (done && st_late_col && !retry_req));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && !frame_start) |=>
      $stable({st_col_cnt, st_excess_col, st_late_col, st_excess_defer, st_deferred, st_err}));

  p_excess_tally_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && st_excess_col) |-> (st_col_cnt == '0));

endmodule

// File: tb/hdx_txstat_tracker_test.sv
module hdx_txstat_tracker_test;

  localparam int LIM_STD   = 24288;
  localparam int LIM_JUMBO = 155680;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 0, attempt_start = 0, tx_end = 0, col_in = 0, crs_in = 0;
  logic byte_tick = 0, bit_tick = 0, backoff_done = 0;
  logic retry_disable = 0, defer_chk_en = 0, jumbo_en = 0;
  logic retry_req, done, st_excess_col, st_late_col, st_excess_defer, st_deferred, st_err;
  logic [3:0] st_col_cnt;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  hdx_txstat_tracker uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .attempt_start(attempt_start),
    .tx_end(tx_end), .col_in(col_in), .crs_in(crs_in), .byte_tick(byte_tick),
    .bit_tick(bit_tick), .backoff_done(backoff_done), .retry_disable(retry_disable),
    .defer_chk_en(defer_chk_en), .jumbo_en(jumbo_en), .retry_req(retry_req), .done(done),
    .st_col_cnt(st_col_cnt), .st_excess_col(st_excess_col), .st_late_col(st_late_col),
    .st_excess_defer(st_excess_defer), .st_deferred(st_deferred), .st_err(st_err)
  );

  // vector fields: collisions, ending (0 ok, 1 late, 2 abort on last), no-retry, cc, ec, lc
  localparam int NV = 8;
  localparam int VEC [NV][6] = '{
    '{0,  0, 0, 0,  0, 0},
    '{3,  0, 0, 3,  0, 0},
    '{0,  0, 0, 0,  0, 0},
    '{15, 0, 0, 15, 0, 0},
    '{16, 2, 0, 0,  1, 0},
    '{1,  2, 1, 0,  1, 0},
    '{2,  1, 0, 2,  0, 1},
    '{0,  0, 1, 0,  0, 0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic new_frame();
    frame_start = 1; step(); frame_start = 0;
  endtask

  task automatic attempt(input int nbytes);
    attempt_start = 1; step(); attempt_start = 0;
    byte_tick = 1;
    repeat (nbytes) step();
    byte_tick = 0;
  endtask

  task automatic collide();
    col_in = 1; step(); col_in = 0;
  endtask

  task automatic backoff(input string req);
    check(req, int'(retry_req), 1);
    check(req, int'(done), 0);
    step(); step();
    check(req, int'(retry_req), 1);
    backoff_done = 1; step(); backoff_done = 0;
    check(req, int'(retry_req), 0);
  endtask

  task automatic run_vec(input int v);
    int ncol = VEC[v][0];
    int kind = VEC[v][1];
    string tg = (kind == 0) ? "R2" : (kind == 1) ? "R6" : (VEC[v][2] != 0) ? "R5" : "R4";
    logic [3:0] held;
    retry_disable = logic'(VEC[v][2]);
    new_frame();
    for (int i = 0; i < ncol; i++) begin
      attempt(10);
      collide();
      if (!(kind == 2 && i == ncol - 1)) backoff("R3");
    end
    if (kind == 0) begin
      attempt(20);
      tx_end = 1; step(); tx_end = 0;
    end else if (kind == 1) begin
      attempt(64);
      collide();
    end
    check(tg, int'(done), 1);
    check((v == 2) ? "R12" : tg, int'(st_col_cnt), VEC[v][3]);
    check(tg, int'(st_excess_col), VEC[v][4]);
    check(tg, int'(st_late_col), VEC[v][5]);
    check(tg, int'(retry_req), 0);
    check("R10", int'(st_err), (VEC[v][4] != 0 || VEC[v][5] != 0) ? 1 : 0);
    check("R9", int'(st_deferred), 0);
    held = st_col_cnt;
    step(); step();
    check("R11", int'(done), 0);
    check("R11", int'(st_col_cnt), int'(held));
    retry_disable = 0;
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit early;
    step(); step();
    rst_n = 1;
    step();
    // R1 reset state
    check("R1", int'(done), 0);
    check("R1", int'(retry_req), 0);
    check("R1", int'(st_col_cnt), 0);
    check("R1", int'({st_excess_col, st_late_col, st_excess_defer, st_deferred, st_err}), 0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R6 window edge: 63 byte times is still early, 64 is late
    new_frame();
    attempt(63);
    collide();
    check("R6", int'(st_late_col), 0);
    backoff("R6");
    attempt(64);
    collide();
    check("R6", int'(done), 1);
    check("R6", int'(st_late_col), 1);
    check("R6", int'(st_col_cnt), 1);
    step();

    // R7 exact standard deferral limit, R9 deferred flag
    defer_chk_en = 1;
    new_frame();
    crs_in = 1; bit_tick = 1;
    early = 0;
    repeat (LIM_STD) begin step(); if (done) early = 1; end
    check("R7", int'(early), 0);
    step();
    check("R7", int'(done), 1);
    check("R7", int'(st_excess_defer), 1);
    check("R9", int'(st_deferred), 1);
    check("R10", int'(st_err), 1);
    check("R7", int'(st_col_cnt), 0);
    crs_in = 0; bit_tick = 0;
    step();

    // R7 check disabled, then R8 jumbo limit continues from the held count
    defer_chk_en = 0;
    new_frame();
    crs_in = 1; bit_tick = 1;
    early = 0;
    repeat (LIM_STD + 2) begin step(); if (done) early = 1; end
    check("R7", int'(early), 0);
    jumbo_en = 1; defer_chk_en = 1;
    repeat (LIM_JUMBO - LIM_STD) begin step(); if (done) early = 1; end
    check("R8", int'(early), 0);
    step();
    check("R8", int'(done), 1);
    check("R8", int'(st_excess_defer), 1);
    crs_in = 0; bit_tick = 0; jumbo_en = 0; defer_chk_en = 0;
    step();

    // R1 accepted frame clears status
    new_frame();
    check("R1", int'({st_excess_col, st_late_col, st_excess_defer, st_deferred, st_err}), 0);
    check("R1", int'(st_col_cnt), 0);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule